// File: doc/BRIEF.md
# Burst Program Word Buffer Loader

This block sits on the host write path of a flash-style memory controller and handles a fast programming mode. Writing the activation command puts it in loading mode. The host then makes exactly 32 write cycles. Each one carries a data word and repeats the same word address, which must sit on a 32-word boundary. The host does not poll between these cycles. The words are kept in an internal 32-entry buffer.

When the 32nd word has been accepted, the block reports busy and streams the buffer to a programming engine. It offers one word at a time over a request/done handshake, in buffer index order, and skips every all-ones word because such a word leaves its cell unchanged. A host with fewer than 32 words pads the burst with FFFFh. An address fault during loading sets an error flag, drops the buffer and returns the block to idle.

Top module: `burst_word_loader`

## Requirements
- R1: After reset the status shows ready (bit 7 = 1), no address fault (bit 4 = 0) and not loading (bit 0 = 0), and prog_req is low.
- R2: In idle, a write whose low data byte is 10h enters loading mode, and status bit 0 reads 1 from the next cycle. Any other idle write is ignored.
- R3: While loading, the k-th accepted write (k = 0..31) is stored in buffer slot k. Status bit 7 stays 1 during loading and drops to 0 only in the cycle after the 32nd word is accepted.
- R4: If the first word's address has a nonzero value in its low 5 bits, status bit 4 is set, loading ends and no word is programmed.
- R5: If a later word's address differs from the first word's address, status bit 4 is set, loading ends and no word is programmed. This also applies to the 32nd word. Bit 4 is cleared only by the next activation command.
- R6: While programming, prog_req offers slot i with prog_addr = start address + i and prog_data = slot i, in rising i. It holds prog_req, prog_addr and prog_data steady until prog_done is sampled high.
- R7: A slot holding FFFFh is skipped without a request, so a burst of all-ones words makes no handshake at all.
- R8: Status bit 7 returns to 1 once slot 31 has been completed or skipped. Host writes made while programming are ignored, and prog_req is never high while status bit 7 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | AW | Host word address |
| wr_data | input | 16 | Host write data or command code |
| status | output | 8 | Bit 7 ready, bit 4 address fault, bit 0 loading; other bits zero |
| prog_req | output | 1 | Word offered to the programming engine |
| prog_addr | output | AW | Address of the offered word |
| prog_data | output | 16 | Data of the offered word |
| prog_done | input | 1 | Engine finished the offered word |

## Verification
Two functions can fall in the same cycle: completion of loading on the 32nd write, and the address check on that same write. The bench provokes this by giving the 32nd word a changed address, and it passes only if the fault wins: bit 4 is set, bit 7 never drops and no request appears. A second overlap sets a host write, including the activation code, against the engine's final prog_done. That write must not start a new load. A behavioural model of the loader is compared with every output on every clock while prog_done follows a pseudo-random pattern.

// File: rtl/burst_word_loader.sv
module burst_word_loader #(
  parameter int AW = 22,
  parameter int DW = 16,
  parameter int WORDS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [7:0]    status,
  output logic          prog_req,
  output logic [AW-1:0] prog_addr,
  output logic [DW-1:0] prog_data,
  input  logic          prog_done
);
  localparam int IW = $clog2(WORDS);
  localparam logic [DW-1:0] BLANK = '1;
  localparam logic [7:0] ACT_CODE = 8'h10;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} st_t;

  st_t           st;
  logic [IW-1:0] cnt;
  logic [AW-1:0] base;
  logic          fault;
  logic [DW-1:0] slot [WORDS];

  wire last    = cnt == IW'(WORDS - 1);
  wire addr_ok = (cnt == '0) ? (wr_addr[IW-1:0] == '0) : (wr_addr == base);
  wire skip    = slot[cnt] == BLANK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      base  <= '0;
      fault <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (wr_en && wr_data[7:0] == ACT_CODE) begin
          st    <= S_LOAD;
          cnt   <= '0;
          fault <= 1'b0;
        end
        S_LOAD: if (wr_en) begin
          if (!addr_ok) begin
            fault <= 1'b1;
            st    <= S_IDLE;
            cnt   <= '0;
          end else begin
            if (cnt == '0) base <= wr_addr;
            if (last) begin
              st  <= S_PROG;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
        end
        S_PROG: if (skip || prog_done) begin
          if (last) begin
            st  <= S_IDLE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (st == S_LOAD && wr_en) slot[cnt] <= wr_data;

  assign prog_req  = (st == S_PROG) && !skip;
  assign prog_addr = {base[AW-1:IW], cnt};
  assign prog_data = slot[cnt];
  assign status    = {st != S_PROG, 2'b00, fault, 3'b000, st == S_LOAD};

  // R6
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req && !prog_done |=> prog_req && $stable(prog_addr) && $stable(prog_data));
  // R3
  busy_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[7]) |-> $past(status[0] && wr_en));
  // R4
  fault_ends_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[4]) |-> $past(status[0] && wr_en) && status[7] && !status[0]);
  // R5
  fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[4]) |-> $past(wr_en && wr_data[7:0] == ACT_CODE));
  // R8
  no_req_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] |-> !prog_req);
  // R6
  addr_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> prog_addr[AW-1:IW] == base[AW-1:IW]);
endmodule

// File: tb/sim_burst_word_loader.sv
module sim_burst_word_loader;
  localparam int AW = 22;
  logic clk = 0, rst_n = 0, wr_en = 0, prog_done = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0] status;
  logic prog_req;
  logic [AW-1:0] prog_addr;
  logic [15:0] prog_data;

  burst_word_loader #(.AW(AW), .DW(16), .WORDS(32)) u0 (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0, hs = 0;
  bit done_flag = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // behavioural reference model
  int mode = 0, pos = 0;
  logic [AW-1:0] mbase = '0;
  logic [15:0] mw [32];
  bit merr = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      mode = 0; pos = 0; merr = 0;
    end else if (mode == 0) begin
      if (wr_en && wr_data[7:0] == 8'h10) begin mode = 1; pos = 0; merr = 0; end
    end else if (mode == 1) begin
      if (wr_en) begin
        if ((pos == 0 && wr_addr % 32 != 0) || (pos != 0 && wr_addr != mbase)) begin
          merr = 1; mode = 0; pos = 0;
        end else begin
          if (pos == 0) mbase = wr_addr;
          mw[pos] = wr_data;
          if (pos == 31) begin mode = 2; pos = 0; end else pos++;
        end
      end
    end else begin
      if (mw[pos] == 16'hFFFF || prog_done) begin
        if (pos == 31) begin mode = 0; pos = 0; end else pos++;
      end
    end
    if (rst_n && prog_req && prog_done) hs++;
  end

  // per-cycle comparison
  always @(negedge clk) if (rst_n) begin
    bit er;
    er = (mode == 2) && mw[pos] != 16'hFFFF;
    check(status[7] == (mode != 2), "R3", "ready bit", status[7], mode != 2);
    check(status[0] == (mode == 1), "R2", "loading bit", status[0], mode == 1);
    check(status[4] == merr, "R5", "fault bit", status[4], merr);
    check(prog_req == er, "R7", "prog_req", prog_req, er);
    if (er) begin
      check(prog_addr == mbase + AW'(pos), "R6", "prog_addr", prog_addr, mbase + AW'(pos));
      check(prog_data == mw[pos], "R6", "prog_data", prog_data, mw[pos]);
    end
  end

  // engine stub: pseudo-random done
  logic [7:0] lfsr = 8'h5B;
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    prog_done = lfsr[0] | lfsr[2];
  end

  task automatic put(input logic [AW-1:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic logic [15:0] pat(input int i, input int fill);
    if (fill == 2 || (fill == 1 && i % 4 == 3) || (fill == 3 && i >= 20)) return 16'hFFFF;
    return {8'(i) ^ 8'hA5, 8'h20 + 8'(i)};
  endfunction

  // writes n words; word bad_i gets address+1
  task automatic burst(input logic [AW-1:0] b, input int n, input int bad_i, input int fill);
    put(22'h0, 16'h0010);
    for (int i = 0; i < n; i++) put(i == bad_i ? b + 1 : b, pat(i, fill));
  endtask

  task automatic wait_ready();
    for (int k = 0; k < 400 && !status[7]; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int h0, expect_hs;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(status == 8'h80 && !prog_req, "R1", "reset status", status, 8'h80);
    // R2 non-activation write ignored
    put(22'h40, 16'h0040);
    @(negedge clk);
    check(status[0] == 0, "R2", "ignored write", status[0], 0);
    // R3 R6 R7 full burst with some blank words
    h0 = hs;
    burst(22'h1A40, 32, -1, 1);
    check(status[7] == 0, "R3", "busy after 32nd", status[7], 0);
    put(22'h0, 16'h0010);
    wait_ready();
    @(negedge clk);
    check(status[0] == 0, "R8", "write during programming ignored", status[0], 0);
    check(hs - h0 == 24, "R7", "handshake count", hs - h0, 24);
    // R4 unaligned start
    h0 = hs;
    burst(22'h1A43, 1, -1, 0);
    check(status == 8'h90, "R4", "unaligned fault", status, 8'h90);
    repeat (5) @(negedge clk);
    check(hs == h0, "R4", "no programming", hs - h0, 0);
    // R5 changed address mid-burst, then activation clears fault
    burst(22'h2000, 11, 10, 0);
    check(status == 8'h90, "R5", "mismatch fault", status, 8'h90);
    put(22'h0, 16'hAB10);
    check(status == 8'h81, "R5", "fault cleared by activation", status, 8'h81);
    for (int i = 0; i < 32; i++) put(i == 31 ? 22'h2001 : 22'h2000, pat(i, 0));
    check(status == 8'h90, "R5", "fault on 32nd word wins", status, 8'h90);
    repeat (3) @(negedge clk);
    check(hs == h0, "R5", "no programming after fault", hs - h0, 0);
    // R7 all-blank burst
    burst(22'h3000, 32, -1, 2);
    wait_ready();
    check(hs == h0, "R7", "all blank no handshake", hs - h0, 0);
    // R6 short burst padded, activation during final done
    burst(22'h0FE0, 32, -1, 3);
    expect_hs = 20;
    for (int k = 0; k < 400 && !status[7]; k++) begin
      wr_en = 1; wr_addr = 22'h0; wr_data = 16'h0010;
      @(negedge clk);
    end
    wr_en = 0;
    check(status[7] == 1, "R8", "ready after last", status[7], 1);
    check(hs - h0 == expect_hs, "R6", "padded burst handshakes", hs - h0, expect_hs);
    repeat (3) @(negedge clk);
    check(status[0] == 0, "R8", "no load from writes in programming", status[0], 0);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule